// File: doc/BRIEF.md
# Capture-Compare General Purpose Timer

This block is a timer peripheral built around an up-counter. The counter is paced by a clock-enable tick, which first passes through a programmable divider. The counter can wrap freely, or it can restart from zero once it reaches the first compare value. Three compare channels watch the counter. Each one drives an output pin that can toggle, clear, set or emit a one-count low pulse when the counter reaches its value. Software can also apply a pin action at once through force bits.

Two capture inputs are synchronized and examined for a selectable edge. On a qualifying edge, the current count is latched. Every compare match, capture and wrap raises a sticky status flag. Each flag has its own enable, and the enabled flags are combined into one registered interrupt line.

Software reaches the block through a word-wide register port. Writes are single-cycle and reads are combinational. A self-clearing soft reset returns every register to zero.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, every register reads 0, `cmp_out` is 0 and `irq` is 0.
- R2: The divider value lives at byte offset 0x04. While control bit 0 is set, the counter advances once for every (value+1) cycles in which `tick` is high. Cycles with `tick` low, or with bit 0 clear, do not advance it.
- R3: With control bit 9 set, the counter wraps from all ones to 0. The wrap sets status bit 5.
- R4: With control bit 9 clear, a counter that holds compare-1 goes to 0 on its next advance.
- R5: A counter advance whose new value equals compare register n sets status bit n-1. Compare registers 1, 2 and 3 sit at offsets 0x10, 0x14 and 0x18.
- R6: Pin modes sit at control bits 22:20, 25:23 and 28:26 for channels 1, 2 and 3. Code 0 drives the pin low. Code 1 toggles the pin on a match, code 2 clears it and code 3 sets it. Codes 4 to 7 hold the pin high and drive it low for one count after a match.
- R7: Writing 1 to control bit 29, 30 or 31 applies the pin action of channel 1, 2 or 3 at the next edge. These bits always read back as 0.
- R8: Edge selects sit at control bits 17:16 for capture 1 and 19:18 for capture 2. Code 0 is off, 1 is rising, 2 is falling and 3 is both edges. A qualifying edge latches the count into offset 0x1C or 0x20 and sets status bit 3 or 4. The flag appears on the third clock edge after the input changes.
- R9: Status (offset 0x08) is write-1-to-clear. When an event and a clear of the same bit meet in one cycle, the bit stays set.
- R10: `irq` is the OR of status ANDed with the enable register (offset 0x0C, same bit positions). It is registered, so it follows one cycle after the flags.
- R11: Writing control bit 15 makes it read 1 for one cycle. On the following edge every register returns to 0.
- R12: The counter at offset 0x24 is read-only. With bit 9 clear, a write to any compare register clears the counter; with bit 9 set, the counter is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable feeding the divider |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cap_in | input | 2 | Capture inputs |
| cmp_out | output | 3 | Compare pins |
| irq | output | 1 | Interrupt request |

## Verification
A divider or counter that has drifted shows up at once in the value read at offset 0x24. Such a fault then fires compare flags and pin changes on the wrong count, so the first disagreement is one count period after the fault. Broken synchronizer or edge state moves the capture flag off its third-edge slot, or raises it for an edge that was not selected. A stale flag or enable produces a wrong `irq` exactly one cycle after the status changes.

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [1:0]  cap_in,
  output logic [2:0]  cmp_out,
  output logic        irq
);
  timeunit 1ns; timeprecision 1ps;

  localparam int NCMP = 3;
  localparam int NCAP = 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [5:0] A_CTRL = 6'h00, A_PRE = 6'h04, A_STS = 6'h08, A_IEN = 6'h0C;
  localparam logic [5:0] A_CMP1 = 6'h10, A_CAP1 = 6'h1C, A_CNT = 6'h24;

  logic [28:0]      ctrl_q;
  logic             srst_q;
  logic [PRE_W-1:0] pre_q, div_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [5:0]       sts_q, ien_q, evt, clr;
  logic             irq_q;
  logic [NCMP-1:0][CNT_W-1:0] cmp_val;
  logic [NCAP-1:0][CNT_W-1:0] cap_val;
  logic [NCMP-1:0]  cmp_wr, cmp_evt;
  logic [NCAP-1:0]  cap_evt;

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire srst_req = wr_ctrl && reg_wdata[15];
  wire ctrl_ld  = wr_ctrl && !reg_wdata[15];
  wire run      = ctrl_q[0];
  wire frr      = ctrl_q[9];
  wire cnt_clr  = !frr && |cmp_wr;
  wire step     = run && tick && div_q >= pre_q;
  wire adv      = step && !cnt_clr;

  assign cnt_nx = (!frr && cnt_q == cmp_val[0]) ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) srst_q <= 1'b0;
    else        srst_q <= srst_req && !srst_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (srst_q)  ctrl_q <= '0;
    else if (ctrl_ld) ctrl_q <= reg_wdata[28:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      begin pre_q <= '0; ien_q <= '0; end
    else if (srst_q) begin pre_q <= '0; ien_q <= '0; end
    else begin
      if (reg_wr && reg_addr == A_PRE) pre_q <= reg_wdata[PRE_W-1:0];
      if (reg_wr && reg_addr == A_IEN) ien_q <= reg_wdata[5:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              div_q <= '0;
    else if (srst_q || !run) div_q <= '0;
    else if (tick)           div_q <= (div_q >= pre_q) ? '0 : div_q + PRE_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt_q <= '0;
    else if (srst_q)  cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (adv)     cnt_q <= cnt_nx;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    logic [CNT_W-1:0] val_q;
    logic pin_q, pls_q;
    wire [2:0] mode  = ctrl_q[20+3*i +: 3];
    wire [2:0] wmode = reg_wdata[20+3*i +: 3];
    wire       frc   = ctrl_ld && reg_wdata[29+i];
    wire [2:0] amode = frc ? wmode : mode;
    wire       act   = frc || cmp_evt[i];

    assign cmp_wr[i]  = reg_wr && reg_addr == A_CMP1 + 6'(4*i);
    assign cmp_evt[i] = adv && cnt_nx == val_q;
    assign cmp_val[i] = val_q;
    assign cmp_out[i] = (mode == 3'd0) ? 1'b0 : mode[2] ? ~pls_q : pin_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         val_q <= '0;
      else if (srst_q)    val_q <= '0;
      else if (cmp_wr[i]) val_q <= reg_wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      pin_q <= 1'b0;
      else if (srst_q) pin_q <= 1'b0;
      else if (act)
        case (amode)
          3'd1:    pin_q <= ~pin_q;
          3'd2:    pin_q <= 1'b0;
          3'd3:    pin_q <= 1'b1;
          default: pin_q <= pin_q;
        endcase

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                pls_q <= 1'b0;
      else if (srst_q)           pls_q <= 1'b0;
      else if (act && amode[2])  pls_q <= 1'b1;
      else if (adv)              pls_q <= 1'b0;
  end

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    logic [2:0] sy_q;
    logic [CNT_W-1:0] val_q;
    wire [1:0] emode = ctrl_q[16+2*j +: 2];
    wire rise = sy_q[1] & ~sy_q[2];
    wire fall = ~sy_q[1] & sy_q[2];

    assign cap_evt[j] = (emode[0] & rise) | (emode[1] & fall);
    assign cap_val[j] = val_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sy_q <= '0;
      else        sy_q <= {sy_q[1:0], cap_in[j]};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)          val_q <= '0;
      else if (srst_q)     val_q <= '0;
      else if (cap_evt[j]) val_q <= cnt_q;
  end

  assign evt = {adv && cnt_q == CNT_MAX, cap_evt, cmp_evt};
  assign clr = (reg_wr && reg_addr == A_STS) ? reg_wdata[5:0] : 6'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      begin sts_q <= '0; irq_q <= 1'b0; end
    else if (srst_q) begin sts_q <= '0; irq_q <= 1'b0; end
    else begin
      sts_q <= (sts_q & ~clr) | evt;
      irq_q <= |(sts_q & ien_q);
    end

  assign irq = irq_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:        reg_rdata = {3'b000, ctrl_q[28:16], srst_q, ctrl_q[14:0]};
      A_PRE:         reg_rdata = 32'(pre_q);
      A_STS:         reg_rdata = {26'd0, sts_q};
      A_IEN:         reg_rdata = {26'd0, ien_q};
      A_CMP1:        reg_rdata = 32'(cmp_val[0]);
      A_CMP1 + 6'd4: reg_rdata = 32'(cmp_val[1]);
      A_CMP1 + 6'd8: reg_rdata = 32'(cmp_val[2]);
      A_CAP1:        reg_rdata = 32'(cap_val[0]);
      A_CAP1 + 6'd4: reg_rdata = 32'(cap_val[1]);
      A_CNT:         reg_rdata = 32'(cnt_q);
      default:       reg_rdata = '0;
    endcase
  end
endmodule

module capcmp_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             srst,
  input logic             run,
  input logic             frr,
  input logic             adv,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp1,
  input logic             cap0_evt,
  input logic [5:0]       sts,
  input logic [5:0]       ien,
  input logic             irq,
  input logic [5:0]       reg_addr,
  input logic [31:0]      reg_rdata
);
  timeunit 1ns; timeprecision 1ps;
  localparam logic [CNT_W-1:0] MAX = '1;

  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_clr && !srst) |=> $stable(cnt));

  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && frr && cnt == MAX && !srst) |=> (cnt == '0 && sts[5]));

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !frr && cnt == cmp1 && !srst) |=> cnt == '0);

  assert_force_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 6'h00) |-> reg_rdata[31:29] == 3'b000);

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap0_evt && !srst) |=> sts[3]);

  assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(srst) |-> irq == $past(|(sts & ien)));

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (cnt == '0 && sts == 6'd0 && !irq));
endmodule

bind capcmp_timer capcmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .srst(srst_q), .run(ctrl_q[0]), .frr(ctrl_q[9]),
  .adv(adv), .cnt_clr(cnt_clr), .cnt(cnt_q), .cmp1(cmp_val[0]),
  .cap0_evt(cap_evt[0]), .sts(sts_q), .ien(ien_q), .irq(irq),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/test_capcmp_timer.sv
module test_capcmp_timer;
  timeunit 1ns; timeprecision 1ps;

  localparam int CW = 8;
  localparam logic [5:0] A_CTRL = 6'h00, A_PRE = 6'h04, A_STS = 6'h08, A_IEN = 6'h0C;
  localparam logic [5:0] A_CMP1 = 6'h10, A_CMP2 = 6'h14, A_CMP3 = 6'h18;
  localparam logic [5:0] A_CAP1 = 6'h1C, A_CAP2 = 6'h20, A_CNT = 6'h24;
  localparam logic [31:0] RUN = 32'h1, FREE = 32'h200, SRST = 32'h8000;
  localparam logic [31:0] F1 = 32'h2000_0000, F3 = 32'h8000_0000;
  // divider value, counted edges, expected count
  localparam logic [23:0] VEC [8] = '{
    {8'd0, 8'd10, 8'd10}, {8'd1, 8'd10, 8'd5}, {8'd3, 8'd20, 8'd5}, {8'd4, 8'd23, 8'd4},
    {8'd7, 8'd64, 8'd8},  {8'd2, 8'd3,  8'd1}, {8'd0, 8'd1,  8'd1}, {8'd9, 8'd9,  8'd0}};

  logic clk = 0, rst_n = 0, tick = 1, reg_wr = 0, irq;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, rv;
  logic [1:0] cap_in = '0;
  logic [2:0] cmp_out;
  int nvec = 0, nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  capcmp_timer #(.CNT_W(CW), .PRE_W(8)) i_capcmp_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .cmp_out(cmp_out), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic run_for(input logic [31:0] base, input int n);
    wr(A_CTRL, base | RUN);
    repeat (n - 1) @(negedge clk);
    wr(A_CTRL, base);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nbad++; nvec++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(A_CTRL, rv); chk("R1 ctrl", rv, 0);
    rd(A_STS, rv);  chk("R1 status", rv, 0);
    rd(A_CNT, rv);  chk("R1 count", rv, 0);
    rd(A_PRE, rv);  chk("R1 divider", rv, 0);
    chk("R1 pins", 32'(cmp_out), 0);
    chk("R1 irq", 32'(irq), 0);
    @(negedge clk);

    for (int k = 0; k < 8; k++) begin
      wr(A_PRE, 32'(VEC[k][23:16]));
      wr(A_CMP1, 32'hFF);
      run_for(0, int'(VEC[k][15:8]));
      rd(A_CNT, rv); chk($sformatf("R2 vector %0d", k), rv, 32'(VEC[k][7:0]));
      @(negedge clk);
    end

    wr(A_PRE, 0); wr(A_CMP1, 32'hFF);
    tick = 0; run_for(0, 6); tick = 1;
    rd(A_CNT, rv); chk("R2 tick low", rv, 0);
    @(negedge clk);

    wr(A_CNT, 32'h55);
    rd(A_CNT, rv); chk("R12 count read-only", rv, 0);
    @(negedge clk);
    run_for(0, 5); wr(A_CMP3, 32'h40);
    rd(A_CNT, rv); chk("R12 restart clear", rv, 0);
    @(negedge clk);
    run_for(FREE, 5); wr(A_CMP2, 32'h40);
    rd(A_CNT, rv); chk("R12 free-run keep", rv, 5);
    @(negedge clk);

    wr(A_STS, 32'h3F);
    run_for(FREE, 254);
    rd(A_CNT, rv); chk("R3 wrapped count", rv, 3);
    rd(A_STS, rv); chk("R3 R5 flags", rv, 32'h27);
    @(negedge clk);
    wr(A_STS, 32'h20);
    rd(A_STS, rv); chk("R9 selective clear", rv, 32'h07);
    @(negedge clk);

    wr(A_CTRL, 0); wr(A_STS, 32'h3F); wr(A_CMP1, 5);
    run_for(0, 8);
    rd(A_CNT, rv); chk("R4 restart count", rv, 2);
    rd(A_STS, rv); chk("R4 R5 only compare-1", rv, 32'h01);
    @(negedge clk);

    wr(A_CMP1, 32'hFF); wr(A_CMP2, 3);
    run_for(FREE | (32'd1 << 23), 3);
    chk("R6 toggle high", 32'(cmp_out[1]), 1);
    rd(A_STS, rv); chk("R5 compare-2 flag", 32'(rv[1]), 1);
    @(negedge clk);
    run_for(FREE | (32'd1 << 23), 256);
    chk("R6 toggle back", 32'(cmp_out[1]), 0);

    wr(A_CTRL, (32'd3 << 20) | F1);
    chk("R7 force set", 32'(cmp_out[0]), 1);
    rd(A_CTRL, rv); chk("R7 force reads zero", rv, 32'd3 << 20);
    @(negedge clk);
    wr(A_CTRL, 32'd2 << 20);
    chk("R6 clear mode holds", 32'(cmp_out[0]), 1);
    wr(A_CMP1, 2);
    run_for(32'd2 << 20, 2);
    chk("R6 clear on match", 32'(cmp_out[0]), 0);
    wr(A_CTRL, (32'd3 << 20) | F1);
    wr(A_CTRL, F1);
    chk("R6 disconnected low", 32'(cmp_out[0]), 0);

    wr(A_CTRL, 32'd4 << 26);
    chk("R6 pulse idle high", 32'(cmp_out[2]), 1);
    wr(A_CMP1, 32'hFF); wr(A_CMP3, 2);
    run_for(32'd4 << 26, 2);
    chk("R6 pulse low", 32'(cmp_out[2]), 0);
    run_for(32'd4 << 26, 1);
    chk("R6 pulse ends", 32'(cmp_out[2]), 1);
    wr(A_CTRL, (32'd7 << 26) | F3);
    chk("R7 R6 code 7 force pulse", 32'(cmp_out[2]), 0);

    wr(A_CTRL, 32'd1 << 16); wr(A_CMP2, 32'h40);
    run_for(32'd1 << 16, 7);
    wr(A_STS, 32'h3F);
    cap_in[0] = 1;
    @(negedge clk); rd(A_STS, rv); chk("R8 edge 1", 32'(rv[3]), 0);
    @(negedge clk); rd(A_STS, rv); chk("R8 edge 2", 32'(rv[3]), 0);
    @(negedge clk); rd(A_STS, rv); chk("R8 edge 3", 32'(rv[3]), 1);
    rd(A_CAP1, rv); chk("R8 capture value", rv, 7);
    @(negedge clk);
    wr(A_STS, 32'h3F); cap_in[0] = 0; wait_n(4);
    rd(A_STS, rv); chk("R8 fall ignored", 32'(rv[3]), 0);
    @(negedge clk);

    wr(A_CTRL, 32'd2 << 18);
    cap_in[1] = 1; wait_n(4);
    rd(A_STS, rv); chk("R8 rise ignored", 32'(rv[4]), 0);
    @(negedge clk);
    run_for(32'd2 << 18, 3);
    cap_in[1] = 0; wait_n(4);
    rd(A_STS, rv); chk("R8 falling flag", 32'(rv[4]), 1);
    rd(A_CAP2, rv); chk("R8 capture 2 value", rv, 10);
    @(negedge clk);

    wr(A_CTRL, 32'd3 << 16); wr(A_STS, 32'h3F);
    cap_in[0] = 1; wait_n(4);
    rd(A_STS, rv); chk("R8 both rise", 32'(rv[3]), 1);
    @(negedge clk);
    wr(A_STS, 32'h3F); cap_in[0] = 0; wait_n(4);
    rd(A_STS, rv); chk("R8 both fall", 32'(rv[3]), 1);
    @(negedge clk);
    wr(A_CTRL, 0); wr(A_STS, 32'h3F);
    cap_in[0] = 1; wait_n(4);
    rd(A_STS, rv); chk("R8 disabled", 32'(rv[3]), 0);
    @(negedge clk);
    cap_in[0] = 0; wait_n(4);

    wr(A_CTRL, 32'd1 << 16); wr(A_STS, 32'h3F);
    cap_in[0] = 1;
    @(negedge clk); @(negedge clk);
    wr(A_STS, 32'h08);
    rd(A_STS, rv); chk("R9 event beats clear", 32'(rv[3]), 1);
    @(negedge clk);
    wr(A_STS, 32'h08);
    rd(A_STS, rv); chk("R9 clear", 32'(rv[3]), 0);
    @(negedge clk);

    cap_in[0] = 0; wait_n(4);
    wr(A_IEN, 32'h08);
    cap_in[0] = 1; wait_n(3);
    chk("R10 irq lags flag", 32'(irq), 0);
    @(negedge clk);
    chk("R10 irq raised", 32'(irq), 1);
    wr(A_IEN, 0);
    @(negedge clk);
    chk("R10 irq masked", 32'(irq), 0);

    wr(A_PRE, 5); wr(A_CTRL, FREE);
    wr(A_CTRL, SRST);
    rd(A_CTRL, rv); chk("R11 reset bit visible", rv, SRST | FREE);
    @(negedge clk);
    rd(A_CTRL, rv); chk("R11 ctrl cleared", rv, 0);
    rd(A_PRE, rv);  chk("R11 divider cleared", rv, 0);
    rd(A_CMP1, rv); chk("R11 compare cleared", rv, 0);
    rd(A_STS, rv);  chk("R11 status cleared", rv, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule